// File: doc/BRIEF.md
# Strobe-Bus to Static RAM Bridge

This block lets an older memory bus, built around a row strobe, a column strobe, a read/write level and two byte strobes, drive a 16-bit asynchronous static RAM. Two masters share the bus in alternating halves of each bus cycle. The CPU uses one half and sets the byte strobes correctly. The video fetcher uses the other half, only reads, and leaves both byte strobes idle. A CPU write is always followed by a video read. The bridge therefore turns on both byte lanes for every read, passes the byte strobes through only for writes, and drops the write pulse as soon as the byte strobes go idle, so that the RAM has time to recover before the next read.

Memory size is set by a two-bit jumper input. For an access that falls outside the selected size, the bridge gates off both the row and the column strobe. The RAM chip enable is built only from these gated strobes. The multiplexed address is rebuilt into a linear word address: the row half is captured when the row strobe falls, and the column half is taken from the bus while the column strobe is active.

All inputs are sampled on a fast local clock. Every RAM control output is registered, so each output follows its inputs by one clock.

Top module: `strobe_sram_bridge`

## Requirements
- R1: The chip enable is active in the cycle after both row strobe and column strobe are sampled active and the access is in range. In all other cases it is inactive.
- R2: During a read (read level 1) with chip enable active, both byte enables are active, even when the incoming byte strobes are idle.
- R3: During a write (read level 0), the upper byte enable follows the upper byte strobe and the lower byte enable follows the lower byte strobe, both one clock later.
- R4: Write enable is active only while the chip is enabled, the read level is 0 and at least one byte strobe is active. It goes inactive one clock after both byte strobes go idle, even when the read level stays 0.
- R5: The jumper code sel (00=512 KiB, 01=1 MiB, 10=1.5 MiB, 11=2 MiB) admits word address bits 19:18 (the two top row bits) only when those bits are <= sel. Out-of-range accesses never assert chip enable, write enable or output enable.
- R6: The row half is captured on the clock where the row strobe is first seen active. The output address is {row, column}, with the row in bits 19:10. The row stays fixed while the row strobe stays active, even when the bus address changes.
- R7: Output enable is active only for reads with chip enable active, and it is never active together with write enable.
- R8: The data bus is driven only while write enable is active, and it then carries the write data sampled in the same clock.
- R9: While reset is active, chip enable, output enable, write enable and both byte enables are inactive (high), and the data bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| rd_wr | input | 1 | Read level: 1 read, 0 write |
| uds_n | input | 1 | Upper byte strobe, active low |
| lds_n | input | 1 | Lower byte strobe, active low |
| mux_addr | input | 10 | Multiplexed row/column address |
| size_sel | input | 2 | Installed-size jumper code |
| wdata | input | 16 | Write data from the bus |
| sram_addr | output | 20 | Linear word address |
| sram_ce_n | output | 1 | RAM chip enable, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_ub_n | output | 1 | Upper byte enable, active low |
| sram_lb_n | output | 1 | Lower byte enable, active low |
| sram_dq_out | output | 16 | Data driven toward the RAM |
| sram_dq_oe | output | 1 | Data bus drive enable |

## Verification
The hardest cases to reach are write cycles where the byte strobes go idle while the read level is still low, and video reads that arrive with no byte strobes at all. The stimulus builds these cases cycle by cycle: it releases the strobes one clock before the read level rises, and it issues reads with both strobes held idle. Row capture is tested by keeping the row strobe active while the bus address changes to a second column. For every jumper code, accesses are placed in the top admitted bank and in the first bank past it.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  typedef struct packed {
    logic ce;
    logic oe;
    logic we;
    logic ub;
    logic lb;
    logic drive;
  } sbr_ctrl_t;

  localparam sbr_ctrl_t SBR_IDLE = '0;

  // Active-high control decode from gated strobes and bus levels.
  function automatic sbr_ctrl_t make_ctrl(input logic ras_g, input logic cas_g,
                                          input logic rd, input logic up,
                                          input logic lo);
    sbr_ctrl_t c;
    c.ce    = ras_g & cas_g;
    c.ub    = rd | up;
    c.lb    = rd | lo;
    c.oe    = c.ce & rd;
    c.we    = c.ce & ~rd & (up | lo);
    c.drive = c.we;
    return c;
  endfunction

endpackage

// File: rtl/sbr_row_hold.sv
module sbr_row_hold #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ras_act,
  input  logic [W-1:0] row_in,
  output logic [W-1:0] row_eff,
  output logic         ras_fall
);
  logic         ras_seen;
  logic [W-1:0] row_q;

  assign ras_fall = ras_act & ~ras_seen;
  assign row_eff  = ras_fall ? row_in : row_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_seen <= 1'b0;
      row_q    <= '0;
    end else begin
      ras_seen <= ras_act;
      if (ras_fall) row_q <= row_in;
    end
  end
endmodule

// File: rtl/sbr_size_gate.sv
module sbr_size_gate #(
  parameter int SEL_W = 2
) (
  input  logic [SEL_W-1:0] bank,
  input  logic [SEL_W-1:0] size_sel,
  input  logic             ras_act,
  input  logic             cas_act,
  output logic             in_range,
  output logic             ras_ok,
  output logic             cas_ok
);
  // A bank is populated when its index does not exceed the jumper code.
  function automatic logic bank_fits(input logic [SEL_W-1:0] b,
                                     input logic [SEL_W-1:0] s);
    return b <= s;
  endfunction

  assign in_range = bank_fits(bank, size_sel);
  assign ras_ok   = ras_act & in_range;
  assign cas_ok   = cas_act & in_range;
endmodule

// File: rtl/strobe_sram_bridge.sv
module strobe_sram_bridge
  import sbr_pkg::*;
#(
  parameter int MUX_W  = 10,
  parameter int DATA_W = 16,
  parameter int SEL_W  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 rd_wr,
  input  logic                 uds_n,
  input  logic                 lds_n,
  input  logic [MUX_W-1:0]     mux_addr,
  input  logic [SEL_W-1:0]     size_sel,
  input  logic [DATA_W-1:0]    wdata,
  output logic [2*MUX_W-1:0]   sram_addr,
  output logic                 sram_ce_n,
  output logic                 sram_oe_n,
  output logic                 sram_we_n,
  output logic                 sram_ub_n,
  output logic                 sram_lb_n,
  output logic [DATA_W-1:0]    sram_dq_out,
  output logic                 sram_dq_oe
);
  localparam int ADDR_W = 2 * MUX_W;

  logic             ras_act, cas_act;
  logic [MUX_W-1:0] row_eff;
  logic             ras_fall;
  logic             in_range, ras_ok, cas_ok;
  sbr_ctrl_t        ctrl_nxt, ctrl_q;
  logic [ADDR_W-1:0] addr_nxt, addr_q;
  logic [DATA_W-1:0] data_q;

  assign ras_act = ~ras_n;
  assign cas_act = ~cas_n;

  sbr_row_hold #(.W(MUX_W)) u_row (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_act  (ras_act),
    .row_in   (mux_addr),
    .row_eff  (row_eff),
    .ras_fall (ras_fall)
  );

  sbr_size_gate #(.SEL_W(SEL_W)) u_gate (
    .bank     (row_eff[MUX_W-1 -: SEL_W]),
    .size_sel (size_sel),
    .ras_act  (ras_act),
    .cas_act  (cas_act),
    .in_range (in_range),
    .ras_ok   (ras_ok),
    .cas_ok   (cas_ok)
  );

  // Only the gated strobes reach the control decode.
  assign ctrl_nxt = make_ctrl(ras_ok, cas_ok, rd_wr, ~uds_n, ~lds_n);
  assign addr_nxt = {row_eff, mux_addr};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= SBR_IDLE;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      ctrl_q <= ctrl_nxt;
      addr_q <= addr_nxt;
      if (ctrl_nxt.drive) data_q <= wdata;
    end
  end

  assign sram_addr   = addr_q;
  assign sram_ce_n   = ~ctrl_q.ce;
  assign sram_oe_n   = ~ctrl_q.oe;
  assign sram_we_n   = ~ctrl_q.we;
  assign sram_ub_n   = ~ctrl_q.ub;
  assign sram_lb_n   = ~ctrl_q.lb;
  assign sram_dq_oe  = ctrl_q.drive;
  assign sram_dq_out = data_q;
endmodule

// File: rtl/sbr_bridge_chk.sv
module sbr_bridge_chk #(
  parameter int MUX_W = 10,
  parameter int SEL_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ras_n,
  input logic               cas_n,
  input logic               uds_n,
  input logic               lds_n,
  input logic [SEL_W-1:0]   size_sel,
  input logic [2*MUX_W-1:0] sram_addr,
  input logic               sram_ce_n,
  input logic               sram_oe_n,
  input logic               sram_we_n,
  input logic               sram_ub_n,
  input logic               sram_lb_n,
  input logic               sram_dq_oe
);
  // R1
  ce_both_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_ce_n |-> $past(!ras_n && !cas_n));

  // R2
  read_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> (!sram_ub_n && !sram_lb_n));

  // R3
  write_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (sram_ub_n == $past(uds_n) && sram_lb_n == $past(lds_n)));

  // R4
  we_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> $past(!uds_n || !lds_n));

  // R5
  size_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_ce_n |-> (sram_addr[2*MUX_W-1 -: SEL_W] <= $past(size_sel)));

  // R6
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |->
      sram_addr[2*MUX_W-1:MUX_W] == $past(sram_addr[2*MUX_W-1:MUX_W]));

  // R7
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_oe_n && !sram_we_n));

  // R8
  drive_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> !sram_we_n);
endmodule

bind strobe_sram_bridge sbr_bridge_chk #(.MUX_W(MUX_W), .SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ras_n      (ras_n),
  .cas_n      (cas_n),
  .uds_n      (uds_n),
  .lds_n      (lds_n),
  .size_sel   (size_sel),
  .sram_addr  (sram_addr),
  .sram_ce_n  (sram_ce_n),
  .sram_oe_n  (sram_oe_n),
  .sram_we_n  (sram_we_n),
  .sram_ub_n  (sram_ub_n),
  .sram_lb_n  (sram_lb_n),
  .sram_dq_oe (sram_dq_oe)
);

// File: tb/tb_strobe_sram_bridge.sv
module tb_strobe_sram_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int MW = 10;
  localparam int DW = 16;
  localparam int SW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, rd_wr = 1'b1, uds_n = 1'b1, lds_n = 1'b1;
  logic [MW-1:0] mux_addr = '0;
  logic [SW-1:0] size_sel = 2'b11;
  logic [DW-1:0] wdata = '0;
  logic [2*MW-1:0] sram_addr;
  logic sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n, sram_dq_oe;
  logic [DW-1:0] sram_dq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit ce, oe, we, ub, lb, drv;
    logic [2*MW-1:0] addr;
    logic [DW-1:0] data;
  } exp_t;

  exp_t q[$];
  logic [MW-1:0] m_row = '0;
  bit m_prev_ras = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_sram_bridge dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .rd_wr(rd_wr),
    .uds_n(uds_n), .lds_n(lds_n), .mux_addr(mux_addr), .size_sel(size_sel),
    .wdata(wdata), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
    .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_ub_n(sram_ub_n),
    .sram_lb_n(sram_lb_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe)
  );

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  // Driver: one bus cycle per clock, expected item pushed per cycle.
  task automatic cyc(bit r, bit c, bit rw, bit u, bit l, logic [MW-1:0] a,
                     logic [DW-1:0] d);
    exp_t e;
    bit ras_a, ok;
    @(negedge clk);
    ras_n = r; cas_n = c; rd_wr = rw; uds_n = u; lds_n = l; mux_addr = a; wdata = d;
    ras_a = !r;
    if (ras_a && !m_prev_ras) m_row = a;
    m_prev_ras = ras_a;
    ok = (m_row[MW-1 -: SW] <= size_sel);
    e.ce = ras_a && !c && ok;
    e.oe = e.ce && rw;
    e.we = e.ce && !rw && (!u || !l);
    e.ub = rw ? 1'b1 : !u;
    e.lb = rw ? 1'b1 : !l;
    e.drv = e.we;
    e.addr = {m_row, a};
    e.data = d;
    q.push_back(e);
  endtask

  task automatic idle();
    cyc(1, 1, 1, 1, 1, '0, '0);
  endtask

  task automatic do_read(logic [MW-1:0] row, logic [MW-1:0] col, bit video);
    bit s = video ? 1'b1 : 1'b0;
    cyc(0, 1, 1, 1, 1, row, '0);
    cyc(0, 0, 1, s, s, col, '0);
    cyc(0, 0, 1, s, s, col, '0);
    idle();
  endtask

  task automatic do_write(logic [MW-1:0] row, logic [MW-1:0] col, bit u, bit l,
                          logic [DW-1:0] d);
    cyc(0, 1, 0, 1, 1, row, d);
    cyc(0, 0, 0, u, l, col, d);
    cyc(0, 0, 0, u, l, col, d);
    cyc(0, 0, 0, 1, 1, col, d);   // strobes idle, read level still low
    idle();
  endtask

  // Monitor: compares outputs just after each edge.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk("R1", "ce", !sram_ce_n, e.ce);
        chk("R7", "oe", !sram_oe_n, e.oe);
        chk("R4", "we", !sram_we_n, e.we);
        chk(e.oe ? "R2" : "R3", "ub", !sram_ub_n, e.ub);
        chk(e.oe ? "R2" : "R3", "lb", !sram_lb_n, e.lb);
        chk("R8", "dq_oe", sram_dq_oe, e.drv);
        if (e.ce) chk("R6", "addr", sram_addr, e.addr);
        if (e.drv) chk("R8", "dq_out", sram_dq_out, e.data);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    chk("R9", "ce_n", sram_ce_n, 1);
    chk("R9", "oe_n", sram_oe_n, 1);
    chk("R9", "we_n", sram_we_n, 1);
    chk("R9", "ub_n", sram_ub_n, 1);
    chk("R9", "lb_n", sram_lb_n, 1);
    chk("R9", "dq_oe", sram_dq_oe, 0);
    @(negedge clk);
    rst_n = 1'b1;

    size_sel = 2'b11;
    do_read(10'h005, 10'h123, 1);          // R2 video read, no strobes
    do_write(10'h0A0, 10'h3FF, 0, 0, 16'hBEEF);  // R3 R4 both lanes
    do_write(10'h0A1, 10'h010, 0, 1, 16'h1200);  // R3 upper only
    do_write(10'h0A2, 10'h011, 1, 0, 16'h0034);  // R3 lower only
    do_write(10'h0A3, 10'h012, 1, 1, 16'h5555);  // R4 no strobes, no WE
    do_read(10'h3FF, 10'h3FF, 0);          // R7 CPU read top of 2 MiB
    do_write(10'h3C0, 10'h001, 0, 0, 16'hA5A5); // write then video read
    do_read(10'h3C0, 10'h001, 1);

    // R6 row held while the bus address moves to a new column
    cyc(0, 1, 1, 1, 1, 10'h011, '0);
    cyc(0, 0, 1, 1, 1, 10'h0F0, '0);
    cyc(0, 1, 1, 1, 1, 10'h2AA, '0);
    cyc(0, 0, 1, 1, 1, 10'h155, '0);
    idle();

    // R5 every jumper code: top admitted bank and first bank past it
    for (int s = 0; s < 4; s++) begin
      size_sel = s[1:0];
      idle();
      do_read({s[1:0], 8'h05}, 10'h077, 1);
      do_write({s[1:0], 8'h06}, 10'h078, 0, 0, 16'h0F0F);
      if (s < 3) begin
        do_read({s[1:0] + 2'b01, 8'h05}, 10'h077, 1);
        do_write({s[1:0] + 2'b01, 8'h06}, 10'h078, 0, 0, 16'hF0F0);
      end
    end

    idle();
    idle();
    repeat (3) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule